// File: doc/BRIEF.md
# Processor Address Error Detector

This block sits beside the request path of a 32-bit RISC core. It looks at every request the core presents: instruction fetches and data loads and stores. It decides whether the access is illegal. Three separate conditions make an access illegal, and any one of them is enough:

- a user-mode fetch in the upper half of the address space;
- a fetch that is not word aligned while the alignment-enforcing ISA mode is selected;
- a data access whose address is not a multiple of its access size.

The verdict is registered. It appears on `errFlag` in the cycle after the clock edge that sampled the request. A 2-bit `errCause` output tells the three kinds of violation apart. The block does not vector exceptions, translate addresses or react to the error in any way. It only classifies each request.

Top module: `addrErrDetect`

## Requirements
- R1: An instruction fetch (`reqIsFetch`=1) made with `userMode`=1 and address bit 31 set raises `errFlag` with `errCause`=01 (privilege). Data accesses are never privilege checked.
- R2: A kernel-mode fetch (`userMode`=0) to the upper half of the address space raises no privilege error.
- R3: With `alignFetchMode`=1, a fetch whose address bits [1:0] are not 00 raises `errFlag` with `errCause`=10 (fetch misalignment).
- R4: With `alignFetchMode`=0, fetch address bits [1:0] are not checked, and a kernel-mode fetch never raises an error.
- R5: A data access (`reqIsFetch`=0) uses the size encoding 00 byte, 01 halfword, 10 word, 11 doubleword. A word access with address bits [1:0] not 00 raises `errFlag` with `errCause`=11 (data misalignment).
- R6: A halfword data access with address bit 0 set raises `errCause`=11. A byte data access never raises an error.
- R7: A doubleword data access with address bits [2:0] not 000 raises `errCause`=11.
- R8: When a fetch is both a user-mode upper-half access and misaligned under `alignFetchMode`=1, `errCause` is 01. Privilege takes priority.
- R9: A cycle with `reqValid`=0 gives `errFlag`=0 and `errCause`=00 whatever the other inputs are.
- R10: The outputs reflect the request sampled at the previous rising clock edge. While `rstN` is low they are 0 and 00. `errFlag` is 1 exactly when `errCause` is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqAddr | input | 32 | Request byte address |
| reqIsFetch | input | 1 | 1 = instruction fetch, 0 = data load/store |
| reqSize | input | 2 | Data access size: 00 byte, 01 half, 10 word, 11 doubleword |
| userMode | input | 1 | 1 = user privilege, 0 = kernel |
| alignFetchMode | input | 1 | 1 = ISA mode that enforces word-aligned fetches |
| errFlag | output | 1 | Registered address error flag |
| errCause | output | 2 | Registered cause: 00 none, 01 privilege, 10 fetch misalign, 11 data misalign |

## Verification
The bench first targets the overlap of the privilege and fetch-alignment conditions. A design with the wrong priority would report fetch misalignment for a user fetch at an odd upper-half address.

It also checks that the fetch alignment test follows only the ISA-mode bit. A design that ignored the mode would flag odd fetches in the non-enforcing mode, or miss them in the enforcing mode.

Each data size is tried at every low-address offset, so a wrong mask is caught. Such a mask would let a misaligned doubleword through or flag a byte. Privilege is checked on data accesses too: a user store to the upper half must stay legal.

Idle cycles carry addresses that would otherwise fault. A design that did not gate on `reqValid` would raise a stray flag.

// File: rtl/addrErrPkg.sv
package addrErrPkg;

  // Number of low address bits that take part in alignment checks (up to 8-byte).
  localparam int LOW_W = 3;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } accSizeE;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_PRIV  = 2'b01,
    CAUSE_FETCH = 2'b10,
    CAUSE_DATA  = 2'b11
  } causeE;

  // Strobes from control to datapath: which checks apply to this request.
  typedef struct packed {
    logic             privChk;
    logic             fetchAlignChk;
    logic             dataAlignChk;
    logic [LOW_W-1:0] dataMask;
  } chkStrobeT;

endpackage

// File: rtl/addrErrCtrl.sv
module addrErrCtrl
  import addrErrPkg::*;
#(
  parameter int FETCH_BYTES = 4
) (
  input  logic       reqValid,
  input  logic       reqIsFetch,
  input  logic [1:0] reqSize,
  input  logic       userMode,
  input  logic       alignFetchMode,
  output chkStrobeT  strb
);

  logic [LOW_W:0]   sizeBytes;
  logic [LOW_W-1:0] sizeMask;

  // Byte count of the data access: 1 << size; the mask covers the bits that must be zero.
  always_comb begin
    sizeBytes = (LOW_W+1)'(1) << reqSize;
    sizeMask  = LOW_W'(sizeBytes - (LOW_W+1)'(1));
  end

  always_comb begin
    strb               = '0;
    strb.privChk       = reqValid &  reqIsFetch & userMode;
    strb.fetchAlignChk = reqValid &  reqIsFetch & alignFetchMode;
    strb.dataAlignChk  = reqValid & ~reqIsFetch;
    strb.dataMask      = strb.dataAlignChk ? sizeMask : '0;
  end

endmodule

// File: rtl/addrErrDatapath.sv
module addrErrDatapath
  import addrErrPkg::*;
#(
  parameter int FETCH_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrTop,
  input  logic [LOW_W-1:0] addrLow,
  input  chkStrobeT        strb,
  output logic             errFlag,
  output logic [1:0]       errCause
);

  localparam logic [LOW_W-1:0] FETCH_MASK = LOW_W'(FETCH_BYTES - 1);

  logic  privHit;
  logic  fetchMis;
  logic  dataMis;
  causeE causeNxt;

  always_comb begin
    privHit  = strb.privChk & addrTop;
    fetchMis = strb.fetchAlignChk & (|(addrLow & FETCH_MASK));
    dataMis  = strb.dataAlignChk & (|(addrLow & strb.dataMask));
    // Privilege wins over alignment; fetch and data checks are mutually exclusive.
    if (privHit)       causeNxt = CAUSE_PRIV;
    else if (fetchMis) causeNxt = CAUSE_FETCH;
    else if (dataMis)  causeNxt = CAUSE_DATA;
    else               causeNxt = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      errCause <= CAUSE_NONE;
    end else begin
      errFlag  <= privHit | fetchMis | dataMis;
      errCause <= causeNxt;
    end
  end

endmodule

// File: rtl/addrErrDetect.sv
module addrErrDetect
  import addrErrPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FETCH_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsFetch,
  input  logic [1:0]        reqSize,
  input  logic              userMode,
  input  logic              alignFetchMode,
  output logic              errFlag,
  output logic [1:0]        errCause
);

  chkStrobeT strb;

  addrErrCtrl #(.FETCH_BYTES(FETCH_BYTES)) u_ctrl (
    .reqValid      (reqValid),
    .reqIsFetch    (reqIsFetch),
    .reqSize       (reqSize),
    .userMode      (userMode),
    .alignFetchMode(alignFetchMode),
    .strb          (strb)
  );

  addrErrDatapath #(.FETCH_BYTES(FETCH_BYTES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addrTop (reqAddr[ADDR_W-1]),
    .addrLow (reqAddr[LOW_W-1:0]),
    .strb    (strb),
    .errFlag (errFlag),
    .errCause(errCause)
  );

endmodule

// File: rtl/addrErrChecker.sv
module addrErrChecker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       addrTop,
  input logic [2:0] addrLow,
  input logic       reqIsFetch,
  input logic [1:0] reqSize,
  input logic       userMode,
  input logic       alignFetchMode,
  input logic       errFlag,
  input logic [1:0] errCause
);

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(reqValid)) |-> (!errFlag && errCause == 2'b00)); // R9

  AST_USER_UPPER_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(reqValid && reqIsFetch && userMode && addrTop))
      |-> (errFlag && errCause == 2'b01)); // R1

  AST_KERNEL_FETCH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(reqValid && reqIsFetch && !userMode && !alignFetchMode))
      |-> !errFlag); // R2

  AST_FETCH_MISALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(reqValid && reqIsFetch && alignFetchMode && (addrLow[1:0] != 2'b00)
                     && !(userMode && addrTop)))
      |-> (errFlag && errCause == 2'b10)); // R3

  AST_WORD_DATA_MISALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(reqValid && !reqIsFetch && reqSize == 2'b10 && addrLow[1:0] != 2'b00))
      |-> (errFlag && errCause == 2'b11)); // R5

  AST_BYTE_DATA_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(reqValid && !reqIsFetch && reqSize == 2'b00)) |-> !errFlag); // R6

  AST_DWORD_DATA_MISALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(reqValid && !reqIsFetch && reqSize == 2'b11 && addrLow != 3'b000))
      |-> (errFlag && errCause == 2'b11)); // R7

  AST_FLAG_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag == (errCause != 2'b00)); // R10

  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (!errFlag || $isunknown(errFlag)); // R10
  end

endmodule

bind addrErrDetect addrErrChecker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .addrTop       (reqAddr[ADDR_W-1]),
  .addrLow       (reqAddr[2:0]),
  .reqIsFetch    (reqIsFetch),
  .reqSize       (reqSize),
  .userMode      (userMode),
  .alignFetchMode(alignFetchMode),
  .errFlag       (errFlag),
  .errCause      (errCause)
);

// File: tb/test_addrErrDetect.sv
`timescale 1ns/1ps
module test_addrErrDetect;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqIsFetch = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic        userMode = 1'b0;
  logic        alignFetchMode = 1'b0;
  logic        errFlag;
  logic [1:0]  errCause;

  int    checks = 0;
  int    fails = 0;
  logic  havePend = 1'b0;
  logic [2:0] expPend;
  string tagPend;

  always #2.5 clk = ~clk;

  addrErrDetect i_addrErrDetect (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqIsFetch(reqIsFetch), .reqSize(reqSize), .userMode(userMode),
    .alignFetchMode(alignFetchMode), .errFlag(errFlag), .errCause(errCause)
  );

  // Behavioural reference: {flag, cause} for one request.
  function automatic logic [2:0] refModel(logic v, logic [31:0] a, logic f,
                                          logic [1:0] s, logic u, logic m);
    int bytes;
    if (!v) return 3'b000;
    if (f) begin
      if (u && a[31])               return 3'b101;
      if (m && (a % 4) != 0)        return 3'b110;
      return 3'b000;
    end
    bytes = 1 << s;
    if ((a % bytes) != 0) return 3'b111;
    return 3'b000;
  endfunction

  function automatic string tagFor(logic v, logic [31:0] a, logic f,
                                   logic [1:0] s, logic u, logic m);
    if (!v) return "R9";
    if (f) begin
      if (u && a[31] && m && a[1:0] != 0) return "R8";
      if (u && a[31]) return "R1";
      if (m) return "R3";
      return (!u && a[31]) ? "R2" : "R4";
    end
    case (s)
      2'b00: return "R6";
      2'b01: return "R6";
      2'b10: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input logic [2:0] exp, input string tag);
    checks++;
    if ({errFlag, errCause} !== exp) begin
      fails++;
      $display("FAIL %s actual flag=%b cause=%b expected flag=%b cause=%b",
               tag, errFlag, errCause, exp[2], exp[1:0]);
    end
  endtask

  // Drive one request at a falling edge; check the previous one first.
  task automatic drive(input logic v, input logic [31:0] a, input logic f,
                       input logic [1:0] s, input logic u, input logic m);
    @(negedge clk);
    if (havePend) check(expPend, tagPend);
    reqValid = v; reqAddr = a; reqIsFetch = f; reqSize = s;
    userMode = u; alignFetchMode = m;
    expPend  = refModel(v, a, f, s, u, m);
    tagPend  = tagFor(v, a, f, s, u, m);
    havePend = 1'b1;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    checks++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R10: reset holds outputs low even with a faulting request presented.
    reqValid = 1'b1; reqAddr = 32'h8000_0003; reqIsFetch = 1'b1;
    userMode = 1'b1; alignFetchMode = 1'b1;
    repeat (3) @(negedge clk);
    check(3'b000, "R10");
    rstN = 1'b1;
    reqValid = 1'b0;

    // Directed cases
    drive(1, 32'h8000_0000, 1, 2'b00, 1, 0);   // R1 user upper fetch
    drive(1, 32'h8000_0000, 0, 2'b10, 1, 1);   // R1 user upper data: legal
    drive(1, 32'hFFFF_FFFC, 1, 2'b00, 0, 1);   // R2 kernel upper fetch
    drive(1, 32'h0000_1002, 1, 2'b00, 0, 1);   // R3 misaligned fetch
    drive(1, 32'h0000_1001, 1, 2'b00, 1, 1);   // R3 user lower misaligned
    drive(1, 32'h0000_1003, 1, 2'b00, 0, 0);   // R4 not checked
    drive(1, 32'h8000_0001, 1, 2'b00, 0, 0);   // R4 kernel, mode off
    for (int off = 0; off < 8; off++) begin
      drive(1, 32'h0000_2000 + off, 0, 2'b10, 0, 0);   // R5 word
      drive(1, 32'h0000_2000 + off, 0, 2'b01, 1, 1);   // R6 half
      drive(1, 32'h0000_2000 + off, 0, 2'b00, 1, 0);   // R6 byte
      drive(1, 32'h0000_2000 + off, 0, 2'b11, 0, 1);   // R7 doubleword
    end
    drive(1, 32'h8000_0002, 1, 2'b00, 1, 1);   // R8 priority
    drive(0, 32'h8000_0003, 1, 2'b00, 1, 1);   // R9 idle
    drive(0, 32'h0000_0001, 0, 2'b10, 0, 0);   // R9 idle
    drive(1, 32'h8000_0003, 1, 2'b00, 1, 1);   // R8 back-to-back
    drive(1, 32'h0000_0004, 1, 2'b00, 1, 1);   // R10 clears next cycle

    // Random sweep
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] a;
      a = $urandom;
      drive(($urandom % 5) != 0, a, $urandom % 2, 2'($urandom % 4),
            $urandom % 2, $urandom % 2);
    end
    drive(0, 32'h0, 0, 2'b00, 0, 0);
    @(negedge clk);
    check(expPend, tagPend);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule